// File: doc/BRIEF.md
# Uncorrectable and Correctable Error Logger with First-Error Capture

This block keeps the error status of one link interface. Error detectors elsewhere send one-hot pulses: one vector for uncorrectable classes and one for correctable classes. With every uncorrectable pulse they also send the header of the transaction that failed. Each pulse sets a sticky status bit. Software clears a status bit by writing 1 to it.

Each uncorrectable bit has a mask bit and a severity bit. Each correctable bit has only a mask bit. The block records the lowest-indexed unmasked uncorrectable error that arrives while the capture is free. It stores that bit index in a pointer register and the offending header in a four-dword log. It then freezes both until software clears the status bit that the pointer names. Three registered outputs tell downstream logic about each unmasked error: fatal, non-fatal and correctable.

Software uses a simple register port with one-cycle read latency. Word addresses are: 0 uncorrectable status, 1 uncorrectable mask, 2 uncorrectable severity, 3 correctable status, 4 correctable mask, 5 first-error pointer, 8 to 8+HDR_DW-1 header log dwords.

Top module: `err_log_top`

## Requirements
- R1: After a synchronous reset, every status, mask, severity, pointer and header-log register reads 0, and fatal_o, nonfatal_o and cor_o are 0.
- R2: A pulse on err_unc_i[i] sets bit i of the uncorrectable status register (address 0), and the bit stays set. Writing 1 to bit i clears it. Writing 0 has no effect. If an error and a clear of the same bit fall in the same cycle, the bit stays set.
- R3: A pulse on err_cor_i[i] sets bit i of the correctable status register (address 3). That register has the same sticky and write-1-to-clear behaviour.
- R4: The mask registers (addresses 1 and 4) and the severity register (address 2) read back the written value, truncated to the register width.
- R5: When the capture is free and an unmasked uncorrectable error arrives, two things happen together. The pointer register (address 5) then reads bit 31 = 1 with the error's bit index in its low bits. Header-log dword k (address 8+k) then reads err_hdr_i[32k+31:32k] as it was in the error cycle.
- R6: When several unmasked uncorrectable errors arrive in the same cycle, the pointer captures the lowest bit index.
- R7: Once the pointer is valid, later uncorrectable errors still set their status bits, but the pointer and header log keep their values.
- R8: A masked uncorrectable error sets its status bit. It does not load the pointer or header log and drives neither fatal_o nor nonfatal_o.
- R9: The capture re-arms (pointer reads 0) only when software writes 1 to the status bit that the pointer names. Clearing any other status bit leaves the pointer valid.
- R10: One cycle after an unmasked uncorrectable error on bit i, fatal_o is 1 if severity bit i is 1, and nonfatal_o is 1 if severity bit i is 0.
- R11: One cycle after an unmasked correctable error, cor_o is 1. A masked correctable error leaves cor_o at 0.
- R12: rdata_o shows the addressed register in the cycle after rd_en_i. Writes to the pointer register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_unc_i | input | UNC_W | Uncorrectable error pulses, one bit per class |
| err_cor_i | input | COR_W | Correctable error pulses, one bit per class |
| err_hdr_i | input | HDR_DW*32 | Header of the transaction behind the uncorrectable pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| fatal_o | output | 1 | Unmasked uncorrectable error of fatal severity seen last cycle |
| nonfatal_o | output | 1 | Unmasked uncorrectable error of non-fatal severity seen last cycle |
| cor_o | output | 1 | Unmasked correctable error seen last cycle |

## Verification
The status bits, pointer, header log and the three indication outputs all take their new values at the clock edge that samples the error pulse. The bench drives each pulse for exactly one cycle from a falling edge and samples the indications at the next falling edge. Register contents are seen two cycles after the event, because a read strobe issued at a falling edge returns its data at the following falling edge, and every register check goes through that read path. Writes use the same one-cycle window, so a clear is always completed before the next read is issued.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
  localparam int unsigned DWORD_W       = 32;
  localparam int unsigned ADR_UNC_STS   = 0;
  localparam int unsigned ADR_UNC_MASK  = 1;
  localparam int unsigned ADR_UNC_SEV   = 2;
  localparam int unsigned ADR_COR_STS   = 3;
  localparam int unsigned ADR_COR_MASK  = 4;
  localparam int unsigned ADR_FIRST_PTR = 5;
  localparam int unsigned ADR_HDR_BASE  = 8;
  localparam int unsigned PTR_VALID_BIT = 31;
endpackage

// File: rtl/err_status_bank.sv
// Sticky W1C status with mask, optional per-bit severity, registered indications.
module err_status_bank #(
  parameter int unsigned W       = 8,
  parameter bit          HAS_SEV = 1'b1,
  parameter logic [W-1:0] SEV_RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         sts_wr_i,
  input  logic         mask_wr_i,
  input  logic         sev_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] sev_o,
  output logic [W-1:0] hit_o,
  output logic         hi_o,
  output logic         lo_o
);
  logic [W-1:0] sts_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] w1c;

  assign w1c   = sts_wr_i ? wdata_i : '0;
  assign hit_o = evt_i & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q  <= '0;
      mask_q <= '0;
    end else begin
      sts_q <= (sts_q & ~w1c) | evt_i;
      if (mask_wr_i) mask_q <= wdata_i;
    end
  end

  assign sts_o  = sts_q;
  assign mask_o = mask_q;

  generate
    if (HAS_SEV) begin : g_sev
      logic [W-1:0] sev_q;
      logic         hi_q;
      logic         lo_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sev_q <= SEV_RST;
          hi_q  <= 1'b0;
          lo_q  <= 1'b0;
        end else begin
          if (sev_wr_i) sev_q <= wdata_i;
          hi_q <= |(hit_o & sev_q);
          lo_q <= |(hit_o & ~sev_q);
        end
      end
      assign sev_o = sev_q;
      assign hi_o  = hi_q;
      assign lo_o  = lo_q;
    end else begin : g_nosev
      logic any_q;
      logic unused_sev_wr;
      assign unused_sev_wr = sev_wr_i;
      always_ff @(posedge clk) begin
        if (rst) any_q <= 1'b0;
        else     any_q <= |hit_o;
      end
      assign sev_o = '0;
      assign hi_o  = 1'b0;
      assign lo_o  = any_q;
    end
  endgenerate
endmodule

// File: rtl/err_first_capture.sv
// First-error pointer and header log; frozen until the named status bit is cleared.
module err_first_capture
  import err_log_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned HDR_DW = 4,
  parameter int unsigned PTR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [W-1:0]              hit_i,
  input  logic [W-1:0]              clr_i,
  input  logic [HDR_DW*DWORD_W-1:0] hdr_i,
  output logic                      valid_o,
  output logic [PTR_W-1:0]          ptr_o,
  output logic [HDR_DW*DWORD_W-1:0] hdr_o
);
  logic             valid_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] low_idx;
  logic             rearm;
  logic             take;

  // Lowest index wins when pulses coincide.
  always_comb begin
    low_idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (hit_i[i]) low_idx = PTR_W'(i);
    end
  end

  assign rearm = valid_q && clr_i[ptr_q];
  assign take  = (!valid_q || rearm) && (|hit_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ptr_q   <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      ptr_q   <= low_idx;
    end else if (rearm) begin
      valid_q <= 1'b0;
    end
  end

  generate
    for (genvar k = 0; k < HDR_DW; k++) begin : g_dw
      logic [DWORD_W-1:0] dw_q;
      always_ff @(posedge clk) begin
        if (rst)       dw_q <= '0;
        else if (take) dw_q <= hdr_i[k*DWORD_W +: DWORD_W];
      end
      assign hdr_o[k*DWORD_W +: DWORD_W] = dw_q;
    end
  endgenerate

  assign valid_o = valid_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/err_reg_read.sv
// Registered read multiplexer for the register port.
module err_reg_read
  import err_log_pkg::*;
#(
  parameter int unsigned UNC_W  = 8,
  parameter int unsigned COR_W  = 6,
  parameter int unsigned HDR_DW = 4,
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [UNC_W-1:0]          unc_sts_i,
  input  logic [UNC_W-1:0]          unc_mask_i,
  input  logic [UNC_W-1:0]          unc_sev_i,
  input  logic [COR_W-1:0]          cor_sts_i,
  input  logic [COR_W-1:0]          cor_mask_i,
  input  logic                      fe_valid_i,
  input  logic [PTR_W-1:0]          fe_ptr_i,
  input  logic [HDR_DW*DWORD_W-1:0] hdr_i,
  output logic [DWORD_W-1:0]        rdata_o
);
  logic [DWORD_W-1:0] rd_mux;
  logic [DWORD_W-1:0] rdata_q;

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(ADR_UNC_STS))   rd_mux = DWORD_W'(unc_sts_i);
    if (addr_i == ADDR_W'(ADR_UNC_MASK))  rd_mux = DWORD_W'(unc_mask_i);
    if (addr_i == ADDR_W'(ADR_UNC_SEV))   rd_mux = DWORD_W'(unc_sev_i);
    if (addr_i == ADDR_W'(ADR_COR_STS))   rd_mux = DWORD_W'(cor_sts_i);
    if (addr_i == ADDR_W'(ADR_COR_MASK))  rd_mux = DWORD_W'(cor_mask_i);
    if (addr_i == ADDR_W'(ADR_FIRST_PTR) && fe_valid_i) begin
      rd_mux = DWORD_W'(fe_ptr_i);
      rd_mux[PTR_VALID_BIT] = 1'b1;
    end
    for (int k = 0; k < HDR_DW; k++) begin
      if (addr_i == ADDR_W'(ADR_HDR_BASE + k)) rd_mux = hdr_i[k*DWORD_W +: DWORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/err_log_top.sv
module err_log_top
  import err_log_pkg::*;
#(
  parameter int unsigned UNC_W   = 8,
  parameter int unsigned COR_W   = 6,
  parameter int unsigned HDR_DW  = 4,
  parameter int unsigned ADDR_W  = 4,
  parameter logic [UNC_W-1:0] SEV_RST = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [UNC_W-1:0]          err_unc_i,
  input  logic [COR_W-1:0]          err_cor_i,
  input  logic [HDR_DW*DWORD_W-1:0] err_hdr_i,
  input  logic                      wr_en_i,
  input  logic                      rd_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DWORD_W-1:0]        wdata_i,
  output logic [DWORD_W-1:0]        rdata_o,
  output logic                      fatal_o,
  output logic                      nonfatal_o,
  output logic                      cor_o
);
  localparam int unsigned PTR_W = (UNC_W > 1) ? $clog2(UNC_W) : 1;

  logic wr_unc_sts, wr_unc_mask, wr_unc_sev, wr_cor_sts, wr_cor_mask;
  logic [UNC_W-1:0] unc_sts, unc_mask, unc_sev, unc_hit, unc_clr;
  logic [COR_W-1:0] cor_sts, cor_mask, cor_unused_sev, cor_unused_hit;
  logic             cor_unused_hi;
  logic             fe_valid;
  logic [PTR_W-1:0] fe_ptr;
  logic [HDR_DW*DWORD_W-1:0] hdr_log;
  logic             unused_wdata;

  assign wr_unc_sts  = wr_en_i && (addr_i == ADDR_W'(ADR_UNC_STS));
  assign wr_unc_mask = wr_en_i && (addr_i == ADDR_W'(ADR_UNC_MASK));
  assign wr_unc_sev  = wr_en_i && (addr_i == ADDR_W'(ADR_UNC_SEV));
  assign wr_cor_sts  = wr_en_i && (addr_i == ADDR_W'(ADR_COR_STS));
  assign wr_cor_mask = wr_en_i && (addr_i == ADDR_W'(ADR_COR_MASK));
  assign unc_clr     = wr_unc_sts ? wdata_i[UNC_W-1:0] : '0;
  assign unused_wdata = ^wdata_i;

  err_status_bank #(.W(UNC_W), .HAS_SEV(1'b1), .SEV_RST(SEV_RST)) unc_bank_i (
    .clk(clk), .rst(rst), .evt_i(err_unc_i),
    .sts_wr_i(wr_unc_sts), .mask_wr_i(wr_unc_mask), .sev_wr_i(wr_unc_sev),
    .wdata_i(wdata_i[UNC_W-1:0]),
    .sts_o(unc_sts), .mask_o(unc_mask), .sev_o(unc_sev), .hit_o(unc_hit),
    .hi_o(fatal_o), .lo_o(nonfatal_o)
  );

  err_status_bank #(.W(COR_W), .HAS_SEV(1'b0), .SEV_RST('0)) cor_bank_i (
    .clk(clk), .rst(rst), .evt_i(err_cor_i),
    .sts_wr_i(wr_cor_sts), .mask_wr_i(wr_cor_mask), .sev_wr_i(1'b0),
    .wdata_i(wdata_i[COR_W-1:0]),
    .sts_o(cor_sts), .mask_o(cor_mask), .sev_o(cor_unused_sev), .hit_o(cor_unused_hit),
    .hi_o(cor_unused_hi), .lo_o(cor_o)
  );

  err_first_capture #(.W(UNC_W), .HDR_DW(HDR_DW), .PTR_W(PTR_W)) cap_i (
    .clk(clk), .rst(rst), .hit_i(unc_hit), .clr_i(unc_clr), .hdr_i(err_hdr_i),
    .valid_o(fe_valid), .ptr_o(fe_ptr), .hdr_o(hdr_log)
  );

  err_reg_read #(.UNC_W(UNC_W), .COR_W(COR_W), .HDR_DW(HDR_DW), .PTR_W(PTR_W),
                 .ADDR_W(ADDR_W)) rd_i (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .unc_sts_i(unc_sts), .unc_mask_i(unc_mask), .unc_sev_i(unc_sev),
    .cor_sts_i(cor_sts), .cor_mask_i(cor_mask),
    .fe_valid_i(fe_valid), .fe_ptr_i(fe_ptr), .hdr_i(hdr_log),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/err_log_chk.sv
module err_log_chk
  import err_log_pkg::*;
#(
  parameter int unsigned UNC_W  = 8,
  parameter int unsigned COR_W  = 6,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PTR_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [UNC_W-1:0]  err_unc_i,
  input logic [COR_W-1:0]  err_cor_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              fatal_o,
  input logic              nonfatal_o,
  input logic              cor_o,
  input logic [UNC_W-1:0]  unc_sts,
  input logic              fe_valid,
  input logic [PTR_W-1:0]  fe_ptr
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_sts_sets_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    (unc_sts & $past(err_unc_i)) == $past(err_unc_i));

  assert_clr_by_write_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    (|($past(unc_sts) & ~unc_sts)) |->
      ($past(wr_en_i) && $past(addr_i) == ADDR_W'(ADR_UNC_STS)));

  assert_capture_src_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(fe_valid) |-> ((($past(err_unc_i) >> fe_ptr) & UNC_W'(1)) != '0));

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(fe_valid) && !($past(wr_en_i) && $past(addr_i) == ADDR_W'(ADR_UNC_STS)))
      |-> (fe_valid && fe_ptr == $past(fe_ptr)));

  assert_unc_ind_src_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    (fatal_o || nonfatal_o) |-> $past(|err_unc_i));

  assert_cor_ind_src_R11: assert property (@(posedge clk) disable iff (rst || !armed)
    cor_o |-> $past(|err_cor_i));
endmodule

bind err_log_top err_log_chk #(
  .UNC_W(UNC_W), .COR_W(COR_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
) chk_i (
  .clk(clk), .rst(rst), .err_unc_i(err_unc_i), .err_cor_i(err_cor_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .fatal_o(fatal_o), .nonfatal_o(nonfatal_o),
  .cor_o(cor_o), .unc_sts(unc_sts), .fe_valid(fe_valid), .fe_ptr(fe_ptr)
);

// File: tb/err_log_top_tb_top.sv
`timescale 1ns/1ps
module err_log_top_tb_top;
  localparam int UNC_W = 8;
  localparam int COR_W = 6;
  localparam int HDR_DW = 4;
  localparam int HB = HDR_DW * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [UNC_W-1:0] err_unc = '0;
  logic [COR_W-1:0] err_cor = '0;
  logic [HB-1:0]    hdr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic fatal, nonfatal, cor;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] d;
  logic [HB-1:0] hx;

  always #2.5 clk = ~clk;

  err_log_top dut_i (
    .clk(clk), .rst(rst), .err_unc_i(err_unc), .err_cor_i(err_cor), .err_hdr_i(hdr),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .fatal_o(fatal), .nonfatal_o(nonfatal), .cor_o(cor)
  );

  function automatic logic [HB-1:0] hpat(input int s);
    logic [HB-1:0] r;
    for (int k = 0; k < HDR_DW; k++)
      r[k*32 +: 32] = {8'(s), 8'(k), 16'(s * 977 + k * 31 + 16'h5a00)};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [UNC_W-1:0] u, input logic [COR_W-1:0] c,
                       input logic [HB-1:0] h, input logic we, input logic [3:0] a,
                       input logic [31:0] wd);
    @(negedge clk);
    err_unc = u; err_cor = c; hdr = h; wr_en = we; addr = a; wdata = wd;
    @(negedge clk);
    err_unc = '0; err_cor = '0; wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] wd);
    drive('0, '0, '0, 1'b1, a, wd);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic chk_hdr(input string tag, input logic [HB-1:0] e);
    logic [31:0] v;
    for (int k = 0; k < HDR_DW; k++) begin
      rd(4'(8 + k), v);
      chk(tag, v, e[k*32 +: 32]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 fatal", 32'(fatal), 0);
    chk("R1 nonfatal", 32'(nonfatal), 0);
    chk("R1 cor", 32'(cor), 0);
    for (int a = 0; a < 6; a++) begin rd(4'(a), d); chk("R1 reg", d, 0); end
    chk_hdr("R1 hdr", '0);

    // R4 readback with width truncation; R12 read path
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R4 unc mask", d, 32'hFF);
    wr(1, 32'h5A);        rd(1, d); chk("R4 unc mask pat", d, 32'h5A);
    wr(2, 32'hA5A5_A5C3); rd(2, d); chk("R4 sev", d, 32'hC3);
    wr(4, 32'hFFFF_FFFF); rd(4, d); chk("R4 cor mask", d, 32'h3F);
    wr(1, 0); wr(2, 0); wr(4, 0);
    rd(1, d); chk("R12 read latency", d, 0);

    // R2 R5 R7 R9 R10 sweep over every bit and severity
    for (int i = 0; i < UNC_W; i++) begin
      for (int s = 0; s < 2; s++) begin
        int j;
        j = (i + 1) % UNC_W;
        wr(2, s ? (32'd1 << i) : 32'd0);
        hx = hpat(i * 2 + s);
        drive(UNC_W'(1) << i, '0, hx, 1'b0, 0, 0);
        chk("R10 fatal", 32'(fatal), 32'(s));
        chk("R10 nonfatal", 32'(nonfatal), 32'(1 - s));
        rd(0, d); chk("R2 status set", d, 32'd1 << i);
        rd(5, d); chk("R5 pointer", d, 32'h8000_0000 | 32'(i));
        chk_hdr("R5 header", hx);
        drive(UNC_W'(1) << j, '0, hpat(100 + i), 1'b0, 0, 0);
        rd(0, d); chk("R7 status", d, (32'd1 << i) | (32'd1 << j));
        rd(5, d); chk("R7 pointer hold", d, 32'h8000_0000 | 32'(i));
        chk_hdr("R7 header hold", hx);
        wr(0, 32'd1 << j);
        rd(5, d); chk("R9 other clear keeps", d, 32'h8000_0000 | 32'(i));
        wr(0, 0);
        rd(0, d); chk("R2 write zero", d, 32'd1 << i);
        wr(5, 32'h0000_0003);
        rd(5, d); chk("R12 ptr write ignored", d, 32'h8000_0000 | 32'(i));
        wr(0, 32'd1 << i);
        rd(5, d); chk("R9 rearm", d, 0);
        rd(0, d); chk("R2 cleared", d, 0);
      end
    end
    wr(2, 0);

    // R6 all pairs
    for (int i = 0; i < UNC_W; i++) begin
      for (int j = i + 1; j < UNC_W; j++) begin
        drive((UNC_W'(1) << i) | (UNC_W'(1) << j), '0, hpat(200 + i * 8 + j), 1'b0, 0, 0);
        chk("R10 pair nonfatal", 32'(nonfatal), 1);
        rd(5, d); chk("R6 lowest index", d, 32'h8000_0000 | 32'(i));
        wr(0, (32'd1 << i) | (32'd1 << j));
      end
    end

    // R8 masked errors
    wr(1, 32'h4);
    drive(8'h04, '0, hpat(300), 1'b0, 0, 0);
    chk("R8 masked fatal", 32'(fatal), 0);
    chk("R8 masked nonfatal", 32'(nonfatal), 0);
    rd(0, d); chk("R8 masked status", d, 32'h4);
    rd(5, d); chk("R8 no capture", d, 0);
    wr(1, 32'h1);
    hx = hpat(301);
    drive(8'h21, '0, hx, 1'b0, 0, 0);
    rd(5, d); chk("R8 R6 masked low bit skipped", d, 32'h8000_0005);
    chk_hdr("R8 header", hx);
    wr(0, 32'hFF); wr(1, 0);

    // R2 set beats clear in the same cycle
    drive(8'h08, '0, hpat(302), 1'b1, 0, 32'h8);
    rd(0, d); chk("R2 set wins", d, 32'h8);
    rd(5, d); chk("R5 capture during clear", d, 32'h8000_0003);
    wr(0, 32'hFF);

    // R3 R11 correctable
    for (int c = 0; c < COR_W; c++) begin
      drive('0, COR_W'(1) << c, '0, 1'b0, 0, 0);
      chk("R11 cor out", 32'(cor), 1);
      chk("R11 no fatal", 32'(fatal | nonfatal), 0);
      rd(3, d); chk("R3 cor status", d, 32'd1 << c);
      wr(3, 0); rd(3, d); chk("R3 write zero", d, 32'd1 << c);
      wr(3, 32'd1 << c); rd(3, d); chk("R3 cleared", d, 0);
      wr(4, 32'd1 << c);
      drive('0, COR_W'(1) << c, '0, 1'b0, 0, 0);
      chk("R11 masked cor", 32'(cor), 0);
      rd(3, d); chk("R3 masked status", d, 32'd1 << c);
      wr(3, 32'd1 << c); wr(4, 0);
    end
    rd(5, d); chk("R9 pointer idle", d, 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule